// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block models the command interface and storage of a 128-bit one-time-programmable protection register that sits inside a 16-bit flash-style memory. The register holds a lock word, a 64-bit segment fixed at reset-time initialisation, and a 64-bit segment the user may program. The bus master drives write cycles whose data carries command codes. It also drives read cycles, which return array data, register words or the status word depending on the current read mode.

Programming takes a setup command and then one more write cycle. That write supplies the target address and the data, and it can only clear bits. Clearing lock bits closes a segment permanently. A program attempt to a closed segment, or to an address outside the register window, leaves the storage untouched and raises sticky status flags. These flags stay set until a clear-status command.

Top module: `prot_reg_ctrl`

## Requirements
- R1: After reset the read mode is array mode and the status word is 0x0080. The lock word at 0x80 is 0xFFFE. Words 0x81..0x84 hold FACTORY_ID, least significant 16 bits at 0x81. Words 0x85..0x88 are 0xFFFF.
- R2: A write whose low data byte is 0x90 selects identifier mode. In that mode a read at 0x80..0x88 returns the stored word on bus_rdata one clock after the read cycle.
- R3: In identifier mode a read at an address below 0x80 or above 0x88 returns 0x0000.
- R4: A write whose low data byte is 0xFF selects array mode, where every read returns 0xFFFF.
- R5: A write with low byte 0xC0 arms programming. The very next write programs its address with its data, and its data is not decoded as a command.
- R6: Programming only clears bits: the new word is the old word ANDed with the written data.
- R7: The segment at 0x81..0x84 is closed while lock bit 0 is 0, which holds from reset. The segment at 0x85..0x88 is closed while lock bit 1 is 0. A program to a closed segment leaves the word unchanged and sets status bit 4 and status bit 1.
- R8: A program to an address outside 0x80..0x88 changes no word and sets status bit 4 only.
- R9: A write with low byte 0x70 selects status mode, where any read returns the status word. In that word bit 7 is 1, bit 4 is the program error, bit 1 is the lock error, and all other bits are 0.
- R10: A write with low byte 0x50 clears status bits 4 and 1 and leaves the read mode unchanged.
- R11: The program write of R5 leaves the block in status mode.
- R12: Programming 0xFFFD at 0x80 closes the user segment, and no later program can set a cleared lock bit back to 1.
- R13: Writes with any other low byte are ignored: the mode and the storage stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write cycle strobe, one clock per cycle |
| bus_rd | input | 1 | Read cycle strobe, one clock per cycle |
| bus_addr | input | ADDR_W | Word address for both cycle types |
| bus_wdata | input | DATA_W | Write data or command code in bits 7:0 |
| bus_rdata | output | DATA_W | Registered read data, valid one clock after bus_rd |

## Verification
The bench programs a user word twice. A design that overwrote the word instead of ANDing it would show the second data value rather than the intersection. It sends a program write whose data equals the array-mode command code. A design that decoded that data as a command would return 0xFFFF instead of the status word. It probes the factory segment, the user segment after locking, and an address one past the window. A design that confused a closed segment with a bad address would set the lock flag when it should not, or leave it clear when it should set it. It also tries to restore a cleared lock bit. A design that treated lock programming as a plain store would reopen the user segment.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_PSETUP = 8'hC0;
  localparam logic [7:0] CMD_CLRSR  = 8'h50;
  localparam logic [7:0] CMD_RDSR   = 8'h70;

  localparam int SR_READY = 7;
  localparam int SR_PGM   = 4;
  localparam int SR_LOCK  = 1;
endpackage

// File: rtl/prot_cmd_fsm.sv
module prot_cmd_fsm
  import prot_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output rd_mode_e          mode,
  output logic              pgm_go,
  output logic              clr_sr
);
  logic       armed;
  logic [7:0] code;

  assign code   = wr_data[7:0];
  assign pgm_go = wr_en && armed;
  assign clr_sr = wr_en && !armed && (code == CMD_CLRSR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_ARRAY;
      armed <= 1'b0;
    end else if (wr_en) begin
      if (armed) begin
        armed <= 1'b0;
        mode  <= MODE_STATUS;
      end else begin
        case (code)
          CMD_IDENT:  mode  <= MODE_IDENT;
          CMD_ARRAY:  mode  <= MODE_ARRAY;
          CMD_RDSR:   mode  <= MODE_STATUS;
          CMD_PSETUP: armed <= 1'b1;
          default:    ;
        endcase
      end
    end
  end

  // R11: a completed program write always lands in status mode
  a_r11_status_after_pgm: assert property (@(posedge clk) disable iff (rst)
    pgm_go |=> (mode == MODE_STATUS));

  // R5: an armed sequence consumes exactly one write
  a_r5_single_shot: assert property (@(posedge clk) disable iff (rst)
    pgm_go |=> !armed);
endmodule

// File: rtl/prot_word_store.sv
module prot_word_store #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BASE      = 'h80,
  parameter int SEG_WORDS = 4,
  parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pgm_go,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic              clr_sr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_hit,
  output logic              err_pgm,
  output logic              err_lock
);
  localparam int NWORDS = 2 * SEG_WORDS + 1;
  localparam int IDX_W  = $clog2(NWORDS);

  logic [DATA_W-1:0] words [NWORDS];

  logic [ADDR_W-1:0] w_off, r_off;
  logic              w_hit, w_factory, w_user, w_locked;
  logic [IDX_W-1:0]  r_idx;

  function automatic logic [DATA_W-1:0] init_word(input int i);
    logic [DATA_W-1:0] v;
    if (i == 0) begin
      v    = '1;
      v[0] = 1'b0;
    end else if (i <= SEG_WORDS) begin
      v = FACTORY_ID[(i-1)*DATA_W +: DATA_W];
    end else begin
      v = '1;
    end
    return v;
  endfunction

  assign w_off     = pgm_addr - ADDR_W'(BASE);
  assign w_hit     = (pgm_addr >= ADDR_W'(BASE)) && (w_off < ADDR_W'(NWORDS));
  assign w_factory = w_hit && (w_off != '0) && (w_off <= ADDR_W'(SEG_WORDS));
  assign w_user    = w_hit && (w_off > ADDR_W'(SEG_WORDS));
  assign w_locked  = (w_factory && !words[0][0]) || (w_user && !words[0][1]);

  assign r_off  = rd_addr - ADDR_W'(BASE);
  assign rd_hit = (rd_addr >= ADDR_W'(BASE)) && (r_off < ADDR_W'(NWORDS));
  assign r_idx  = rd_hit ? r_off[IDX_W-1:0] : '0;
  assign rd_word = words[r_idx];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= init_word(g);
      else if (pgm_go && w_hit && !w_locked && (w_off == ADDR_W'(g)))
        words[g] <= words[g] & pgm_data;
    end

    // R6: no bit of a stored word ever rises outside reset
    a_r6_clear_only: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((words[g] & ~$past(words[g])) == '0));

    // R7: a program aimed at a closed segment leaves the word as it was
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
      (pgm_go && w_locked && (w_off == ADDR_W'(g))) |=> $stable(words[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pgm  <= 1'b0;
      err_lock <= 1'b0;
    end else if (clr_sr) begin
      err_pgm  <= 1'b0;
      err_lock <= 1'b0;
    end else if (pgm_go) begin
      if (!w_hit) begin
        err_pgm <= 1'b1;
      end else if (w_locked) begin
        err_pgm  <= 1'b1;
        err_lock <= 1'b1;
      end
    end
  end

  // R7: the lock flag never rises without the program flag
  a_r7_flag_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(err_lock) |-> err_pgm);

  // R8: a program outside the window raises only the program flag
  a_r8_range_err: assert property (@(posedge clk) disable iff (rst)
    (pgm_go && !w_hit) |=> (err_pgm && $stable(err_lock)));

  // R12: the factory lock bit stays cleared
  a_r12_factory_lock: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !words[0][0]);
endmodule

// File: rtl/prot_reg_ctrl.sv
module prot_reg_ctrl
  import prot_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BASE      = 'h80,
  parameter int SEG_WORDS = 4,
  parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  rd_mode_e          mode;
  logic              pgm_go, clr_sr;
  logic [DATA_W-1:0] rd_word, status_word;
  logic              rd_hit, err_pgm, err_lock;

  prot_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .wr_data(bus_wdata),
    .mode   (mode),
    .pgm_go (pgm_go),
    .clr_sr (clr_sr)
  );

  prot_word_store #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE      (BASE),
    .SEG_WORDS (SEG_WORDS),
    .FACTORY_ID(FACTORY_ID)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .pgm_go  (pgm_go),
    .pgm_addr(bus_addr),
    .pgm_data(bus_wdata),
    .clr_sr  (clr_sr),
    .rd_addr (bus_addr),
    .rd_word (rd_word),
    .rd_hit  (rd_hit),
    .err_pgm (err_pgm),
    .err_lock(err_lock)
  );

  always_comb begin
    status_word           = '0;
    status_word[SR_READY] = 1'b1;
    status_word[SR_PGM]   = err_pgm;
    status_word[SR_LOCK]  = err_lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (mode)
        MODE_IDENT:  bus_rdata <= rd_hit ? rd_word : '0;
        MODE_STATUS: bus_rdata <= status_word;
        default:     bus_rdata <= '1;
      endcase
    end
  end

  // R9: a status read always reports ready
  a_r9_ready_bit: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mode == MODE_STATUS) |=> bus_rdata[SR_READY]);

  // R3: identifier reads outside the window return zero
  a_r3_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mode == MODE_IDENT && !rd_hit) |=> (bus_rdata == '0));

  // R4: array-mode reads return all ones
  a_r4_array_ones: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mode == MODE_ARRAY) |=> (bus_rdata == '1));
endmodule

// File: tb/prot_reg_ctrl_test.sv
module prot_reg_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  prot_reg_ctrl uut (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    rd_check("R1 array mode after reset", 8'h81, 16'hFFFF);
    wr(8'h00, 16'h0090);
    rd_check("R1 lock word", 8'h80, 16'hFFFE);
    rd_check("R1 factory low word", 8'h81, 16'hCDEF);
    rd_check("R1 factory high word", 8'h84, 16'h0123);
    rd_check("R1 user word", 8'h85, 16'hFFFF);
    wr(8'h00, 16'h0070);
    rd_check("R1 R9 status at reset", 8'h00, 16'h0080);
  endtask

  task automatic t_ident_window();
    wr(8'h00, 16'h0090);
    rd_check("R2 factory word 2", 8'h82, 16'h89AB);
    rd_check("R3 below window", 8'h7F, 16'h0000);
    rd_check("R3 above window", 8'h89, 16'h0000);
    wr(8'h00, 16'h00FF);
    rd_check("R4 array read", 8'h80, 16'hFFFF);
  endtask

  task automatic t_program_user();
    wr(8'h00, 16'h00C0);
    wr(8'h86, 16'h12F0);
    rd_check("R11 status after program", 8'h86, 16'h0080);
    wr(8'h00, 16'h0090);
    rd_check("R5 programmed word", 8'h86, 16'h12F0);
    wr(8'h00, 16'h00C0);
    wr(8'h86, 16'hFF0F);
    wr(8'h00, 16'h0090);
    rd_check("R6 AND of old and new", 8'h86, 16'h1200);
    wr(8'h00, 16'h00C0);
    wr(8'h87, 16'h00FF);
    rd_check("R5 data not decoded as command", 8'h00, 16'h0080);
    wr(8'h00, 16'h0090);
    rd_check("R5 data stored at 0x87", 8'h87, 16'h00FF);
  endtask

  task automatic t_factory_locked();
    wr(8'h00, 16'h00C0);
    wr(8'h82, 16'h0000);
    rd_check("R7 both flags set", 8'h00, 16'h0092);
    wr(8'h00, 16'h0090);
    rd_check("R7 factory word unchanged", 8'h82, 16'h89AB);
    wr(8'h00, 16'h0050);
    rd_check("R10 mode kept after clear", 8'h81, 16'hCDEF);
    wr(8'h00, 16'h0070);
    rd_check("R10 flags cleared", 8'h00, 16'h0080);
  endtask

  task automatic t_out_of_range();
    wr(8'h00, 16'h00C0);
    wr(8'h89, 16'h0000);
    rd_check("R8 program flag only", 8'h00, 16'h0090);
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0090);
    rd_check("R8 user word untouched", 8'h88, 16'hFFFF);
  endtask

  task automatic t_unknown_cmd();
    wr(8'h00, 16'h0090);
    wr(8'h00, 16'h0012);
    rd_check("R13 mode unchanged", 8'h81, 16'hCDEF);
  endtask

  task automatic t_lock_user();
    wr(8'h00, 16'h00C0);
    wr(8'h80, 16'hFFFD);
    wr(8'h00, 16'h0090);
    rd_check("R12 lock word after lock", 8'h80, 16'hFFFC);
    wr(8'h00, 16'h00C0);
    wr(8'h85, 16'h0000);
    rd_check("R7 R12 user closed flags", 8'h00, 16'h0092);
    wr(8'h00, 16'h0090);
    rd_check("R7 R12 user word unchanged", 8'h85, 16'hFFFF);
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h00C0);
    wr(8'h80, 16'hFFFF);
    wr(8'h00, 16'h0090);
    rd_check("R12 lock bits stay cleared", 8'h80, 16'hFFFC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident_window();
    t_program_user();
    t_factory_locked();
    t_out_of_range();
    t_unknown_cmd();
    t_lock_user();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule